// File: doc/BRIEF.md
# USB IN Endpoint Retransmit FIFO

This block is the transmit buffer of a device-side USB IN endpoint. Software pushes the bytes of a transfer into it one at a time, and the serial interface engine pulls them out one packet at a time when the host asks for data. After each packet the engine reports the outcome. An acknowledged packet gives its bytes back to software as free space. A packet that ended in an error or timeout is rewound and offered again on the next request, with no software involvement. Until the host has acknowledged a byte, that byte stays in the buffer.

Software ends a transfer by clearing the in-progress bit. The buffer then sends whatever is left as a final short packet. If the data ended exactly on a packet boundary, that final packet has zero length. When the host acknowledges the final packet, the block raises its end-of-transfer event and sets the bit again. An isochronous mode streams the data instead. Each packet is dropped once it has been sent, whatever the outcome, and there is no end-of-transfer event. Sticky per-packet and end-of-transfer flags feed two interrupt outputs, each through its own enable.

Top module: `usb_in_retx_fifo`

## Requirements
- R1: After reset the free count equals DEPTH, both flags and both interrupts are 0, `in_done` is 1 and `tx_valid` is 0.
- R2: Each accepted write lowers `free_count` by one. A write while `free_count` is 0 is dropped and never appears in any later packet.
- R3: In non-isochronous mode, a `tx_start` while at least `pkt_size` bytes are stored opens a packet of exactly `pkt_size` bytes, given in write order. `tx_end` goes high after the last byte has been taken.
- R4: `tx_nak` goes high in the cycle of a `tx_start` that cannot be served. In non-isochronous mode that is when fewer than `pkt_size` bytes are stored and `in_done` is 1. In isochronous mode it is when nothing is stored. No packet opens after a NAK.
- R5: `hs_ack` while `tx_end` is high releases the packet's bytes, so `free_count` rises by the packet length, and sets `eop_flag`.
- R6: In non-isochronous mode, `hs_err` during a packet leaves `free_count` and `eop_flag` unchanged. The next `tx_start` resends the same bytes.
- R7: A pulse on `in_done_clr` sets `in_done` to 0. The next `tx_start` then sends the remaining bytes as a short packet. Acknowledging that packet sets `eot_flag` and sets `in_done` back to 1.
- R8: If `in_done` is cleared while no bytes are stored, the next `tx_start` opens a zero-length packet: `tx_valid` is 0 and `tx_end` is 1. Acknowledging it sets `eot_flag`.
- R9: `eop_flag` and `eot_flag` stay set until a 1 is written to `eop_clr` or `eot_clr`. A set in the same cycle as a clear wins. `irq_eop` equals `eop_flag` AND `eop_ie`, and `irq_eot` equals `eot_flag` AND `eot_ie`.
- R10: In isochronous mode a `tx_start` sends min(stored, `pkt_size`) bytes whenever any byte is stored. Either `hs_ack` or `hs_err` releases the packet and sets `eop_flag`. `eot_flag` is never set.
- R11: A write accepted in the same cycle as a release leaves `free_count` = old + packet length − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_iso | input | 1 | 1 selects isochronous streaming |
| pkt_size | input | PSW | Maximum packet size in bytes (1..DEPTH) |
| cpu_wr_en | input | 1 | Write strobe for one byte |
| cpu_wr_data | input | 8 | Byte to store |
| in_done_clr | input | 1 | Pulse: all transfer data has been written |
| in_done | output | 1 | In-progress bit; 0 after software marks the transfer complete |
| free_count | output | $clog2(DEPTH)+1 | Bytes that can currently be written |
| eop_clr | input | 1 | Write-1 clear of `eop_flag` |
| eot_clr | input | 1 | Write-1 clear of `eot_flag` |
| eop_ie | input | 1 | Packet interrupt enable |
| eot_ie | input | 1 | Transfer interrupt enable |
| eop_flag | output | 1 | Sticky packet-delivered flag |
| eot_flag | output | 1 | Sticky transfer-complete flag |
| irq_eop | output | 1 | Packet interrupt |
| irq_eot | output | 1 | Transfer interrupt |
| tx_start | input | 1 | Engine asks for a packet |
| tx_nak | output | 1 | No packet can be served (same cycle as `tx_start`) |
| tx_valid | output | 1 | `tx_data` holds a byte of the open packet |
| tx_data | output | 8 | Current packet byte |
| tx_rd | input | 1 | Engine takes the current byte |
| tx_end | output | 1 | All bytes of the open packet have been taken |
| hs_ack | input | 1 | Host acknowledged the packet |
| hs_err | input | 1 | Packet failed (error or timeout) |

## Verification
Two events can land in the same clock edge. A release by the host handshake can coincide with a software write, and the flag set from an acknowledgement can coincide with a write-1 clear. The bench drives `hs_ack` in the same cycle as `cpu_wr_en` and checks that `free_count` equals the old value plus the packet length minus one. It drives `hs_ack` in the same cycle as `eop_clr` and checks that `eop_flag` ends up set, then that a lone clear removes it.

// File: rtl/usb_in_retx_fifo.sv
module usb_in_retx_fifo #(
  parameter int DEPTH = 256,
  parameter int PSW = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_iso,
  input  logic [PSW-1:0] pkt_size,
  input  logic cpu_wr_en,
  input  logic [7:0] cpu_wr_data,
  input  logic in_done_clr,
  output logic in_done,
  output logic [$clog2(DEPTH):0] free_count,
  input  logic eop_clr,
  input  logic eot_clr,
  input  logic eop_ie,
  input  logic eot_ie,
  output logic eop_flag,
  output logic eot_flag,
  output logic irq_eop,
  output logic irq_eot,
  input  logic tx_start,
  output logic tx_nak,
  output logic tx_valid,
  output logic [7:0] tx_data,
  input  logic tx_rd,
  output logic tx_end,
  input  logic hs_ack,
  input  logic hs_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = (PSW > AW + 1) ? PSW : AW + 1;

  logic [7:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_live, rd_cmt, pkt_len, sent;
  logic busy, pkt_iso, pkt_short;

  logic [AW:0] used;
  logic [LW-1:0] used_x, size_x;
  logic full_ok, short_ok, can_send, start_go, wr_go, rd_fire, commit, rewind, eot_set;
  logic [AW:0] start_len;

  assign used     = wr_ptr - rd_cmt;
  assign used_x   = LW'(used);
  assign size_x   = LW'(pkt_size);
  assign full_ok  = used_x >= size_x;
  assign short_ok = cfg_iso ? (used != '0) : !in_done;
  assign can_send = full_ok | short_ok;
  assign start_len = full_ok ? (AW+1)'(pkt_size) : used;
  assign start_go = tx_start & !busy & can_send;
  assign tx_nak   = tx_start & !busy & !can_send;

  assign tx_end   = busy & (sent == pkt_len);
  assign tx_valid = busy & !tx_end;
  assign tx_data  = mem[rd_live[AW-1:0]];
  assign rd_fire  = tx_valid & tx_rd;

  assign commit  = busy & (pkt_iso ? ((hs_ack & tx_end) | hs_err) : (hs_ack & tx_end));
  assign rewind  = busy & !pkt_iso & hs_err & !commit;
  assign eot_set = commit & !pkt_iso & pkt_short & !in_done;

  assign wr_go      = cpu_wr_en & (used != (AW+1)'(DEPTH));
  assign free_count = (AW+1)'(DEPTH) - used;
  assign irq_eop    = eop_flag & eop_ie;
  assign irq_eot    = eot_flag & eot_ie;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr[AW-1:0]] <= cpu_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_live <= '0;
      rd_cmt <= '0;
      pkt_len <= '0;
      sent <= '0;
      busy <= 1'b0;
      pkt_iso <= 1'b0;
      pkt_short <= 1'b0;
      in_done <= 1'b1;
      eop_flag <= 1'b0;
      eot_flag <= 1'b0;
    end else begin
      if (wr_go) wr_ptr <= wr_ptr + 1'b1;
      if (start_go) begin
        busy <= 1'b1;
        pkt_len <= start_len;
        sent <= '0;
        pkt_iso <= cfg_iso;
        pkt_short <= !full_ok;
      end else if (commit) begin
        busy <= 1'b0;
        rd_cmt <= rd_cmt + pkt_len;
        rd_live <= rd_cmt + pkt_len;
      end else if (rewind) begin
        busy <= 1'b0;
        rd_live <= rd_cmt;
      end else if (rd_fire) begin
        rd_live <= rd_live + 1'b1;
        sent <= sent + 1'b1;
      end
      if (eot_set) in_done <= 1'b1;
      else if (in_done_clr) in_done <= 1'b0;
      if (commit) eop_flag <= 1'b1;
      else if (eop_clr) eop_flag <= 1'b0;
      if (eot_set) eot_flag <= 1'b1;
      else if (eot_clr) eot_flag <= 1'b0;
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (AW+1)'(DEPTH));

  a_r3_live_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((rd_live - rd_cmt) <= pkt_len));

  a_r4_nak_no_open: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nak |=> !busy);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pkt_iso && hs_ack && tx_end) |=> (rd_cmt == $past(rd_cmt) + $past(pkt_len)));

  a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pkt_iso && hs_err && !hs_ack) |=> (!busy && rd_live == rd_cmt && rd_cmt == $past(rd_cmt)));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> eop_flag);

  a_r10_iso_no_eot: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pkt_iso) |=> $stable(eot_flag) || $fell(eot_flag));
endmodule

// File: tb/tb_usb_in_retx_fifo.sv
`timescale 1ns/1ps
module tb_usb_in_retx_fifo;
  localparam int DEPTH = 16;
  localparam int PSW = 11;
  localparam int PKT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_iso = 0, cpu_wr_en = 0, in_done_clr = 0;
  logic [PSW-1:0] pkt_size = PSW'(PKT);
  logic [7:0] cpu_wr_data = 0;
  logic eop_clr = 0, eot_clr = 0, eop_ie = 0, eot_ie = 0;
  logic tx_start = 0, tx_rd = 0, hs_ack = 0, hs_err = 0;
  logic in_done, eop_flag, eot_flag, irq_eop, irq_eot, tx_nak, tx_valid, tx_end;
  logic [7:0] tx_data;
  logic [$clog2(DEPTH):0] free_count;

  int checks = 0, fails = 0;
  logic [7:0] got [64];
  int n;
  bit nak, endf;

  usb_in_retx_fifo #(.DEPTH(DEPTH), .PSW(PSW)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); cpu_wr_en = 1; cpu_wr_data = b;
    @(negedge clk); cpu_wr_en = 0;
  endtask

  task automatic fetch();
    @(negedge clk); tx_start = 1; #1; nak = tx_nak;
    @(negedge clk); tx_start = 0; n = 0;
    if (!nak) begin
      for (int i = 0; i < 64; i++) begin
        if (!tx_valid) break;
        got[n] = tx_data; n++; tx_rd = 1;
        @(negedge clk); tx_rd = 0;
      end
    end
    endf = tx_end;
  endtask

  task automatic hs(bit ack);
    @(negedge clk); hs_ack = ack; hs_err = !ack;
    @(negedge clk); hs_ack = 0; hs_err = 0;
  endtask

  task automatic clr_flags();
    @(negedge clk); eop_clr = 1; eot_clr = 1;
    @(negedge clk); eop_clr = 0; eot_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 free", free_count, DEPTH);
    chk("R1 eop", eop_flag, 0);
    chk("R1 eot", eot_flag, 0);
    chk("R1 irq", irq_eop | irq_eot, 0);
    chk("R1 in_done", in_done, 1);
    chk("R1 tx_valid", tx_valid, 0);
  endtask

  task automatic t_packets();
    for (int i = 0; i < 6; i++) wr(8'hA0 + 8'(i));
    chk("R2 free after 6 writes", free_count, DEPTH - 6);
    fetch();
    chk("R3 nak", nak, 0);
    chk("R3 length", n, PKT);
    for (int i = 0; i < PKT; i++) chk("R3 byte order", got[i], 8'hA0 + i);
    chk("R3 tx_end", endf, 1);
    hs(1);
    chk("R5 free released", free_count, DEPTH - 2);
    chk("R5 eop set", eop_flag, 1);
    fetch();
    chk("R4 nak on short data", nak, 1);
    chk("R4 no packet", n, 0);
    @(negedge clk); in_done_clr = 1;
    @(negedge clk); in_done_clr = 0;
    chk("R7 in_done cleared", in_done, 0);
    fetch();
    chk("R7 short length", n, 2);
    chk("R7 short bytes", got[1], 8'hA5);
    chk("R7 eot not before ack", eot_flag, 0);
    hs(1);
    chk("R7 eot set", eot_flag, 1);
    chk("R7 in_done back", in_done, 1);
    chk("R7 free", free_count, DEPTH);
    clr_flags();
  endtask

  task automatic t_retry();
    for (int i = 0; i < 4; i++) wr(8'h30 + 8'(i));
    fetch();
    hs(0);
    chk("R6 free unchanged", free_count, DEPTH - 4);
    chk("R6 no eop", eop_flag, 0);
    fetch();
    chk("R6 resend length", n, PKT);
    chk("R6 resend first", got[0], 8'h30);
    chk("R6 resend last", got[3], 8'h33);
    hs(1);
    chk("R6 release after resend", free_count, DEPTH);
    clr_flags();
  endtask

  task automatic t_zlp();
    for (int i = 0; i < 8; i++) wr(8'(i));
    for (int k = 0; k < 2; k++) begin fetch(); hs(1); end
    @(negedge clk); in_done_clr = 1;
    @(negedge clk); in_done_clr = 0;
    fetch();
    chk("R8 zlp no nak", nak, 0);
    chk("R8 zlp length", n, 0);
    chk("R8 zlp tx_end", endf, 1);
    hs(1);
    chk("R8 eot", eot_flag, 1);
    clr_flags();
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) wr(8'(i));
    chk("R2 full", free_count, 0);
    wr(8'hEE);
    chk("R2 write dropped", free_count, 0);
    for (int k = 0; k < DEPTH / PKT; k++) begin
      fetch();
      chk("R2 drained byte", got[PKT-1], k * PKT + PKT - 1);
      hs(1);
    end
    chk("R2 empty again", free_count, DEPTH);
    fetch();
    chk("R2 dropped byte never sent", nak, 1);
    clr_flags();
  endtask

  task automatic t_flags();
    for (int i = 0; i < 4; i++) wr(8'(i));
    fetch();
    @(negedge clk); hs_ack = 1; eop_clr = 1;
    @(negedge clk); hs_ack = 0; eop_clr = 0;
    chk("R9 set wins over clear", eop_flag, 1);
    chk("R9 irq masked", irq_eop, 0);
    eop_ie = 1; #1;
    chk("R9 irq enabled", irq_eop, 1);
    @(negedge clk); eop_clr = 1;
    @(negedge clk); eop_clr = 0;
    chk("R9 w1c clears", eop_flag, 0);
    chk("R9 irq follows", irq_eop, 0);
    eop_ie = 0;
  endtask

  task automatic t_collide();
    for (int i = 0; i < 4; i++) wr(8'(i));
    fetch();
    @(negedge clk); hs_ack = 1; cpu_wr_en = 1; cpu_wr_data = 8'h77;
    @(negedge clk); hs_ack = 0; cpu_wr_en = 0;
    chk("R11 write with release", free_count, DEPTH - 1);
    @(negedge clk); in_done_clr = 1;
    @(negedge clk); in_done_clr = 0;
    fetch();
    chk("R11 written byte kept", got[0], 8'h77);
    hs(1);
    clr_flags();
  endtask

  task automatic t_iso();
    cfg_iso = 1;
    for (int i = 0; i < 3; i++) wr(8'h50 + 8'(i));
    fetch();
    chk("R10 iso short sent", nak, 0);
    chk("R10 iso length", n, 3);
    hs(0);
    chk("R10 dropped on error", free_count, DEPTH);
    chk("R10 eop", eop_flag, 1);
    chk("R10 no eot", eot_flag, 0);
    fetch();
    chk("R10 nak when empty", nak, 1);
    cfg_iso = 0;
    clr_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_packets();
    t_retry();
    t_zlp();
    t_full();
    t_flags();
    t_collide();
    t_iso();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule